// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block makes every allocation decision of an input-queued virtual-channel router in a single clock cycle. It has five ports and four virtual channels per input port. Each cycle it assigns output virtual channels to head flits and grants crossbar passage to at most one flit per input and per output. The two allocations run side by side. A head flit that does not yet own an output VC may bid for the crossbar in the same cycle, on the assumption that it will win a VC. Flits that already own a VC always outrank such speculative bids.

A speculative crossbar grant is only used when the same head flit also won a free output VC in that cycle and that VC has credit. Otherwise the grant is aborted and the flit stays in its buffer. All arbitration uses least-recently-served matrix arbiters. The arbiters that pick an input VC do not advance on an aborted grant, so the same flit bids again in the next cycle.

The surrounding router supplies the per-VC request state, the route and held VC of each flit, the per-output-VC idle flags and credit-non-zero flags. It then acts on the grants. Buffers, routing, the crossbar and credit transport lie outside. All outputs are combinational from the inputs and the arbiter state. The arbiter state updates at the clock edge.

Top module: `spec_vcsw_alloc`

## Requirements
- R1: After reset, with no request valid, `sw_gnt_o`, `sw_abort_o`, `out_vld_o` and `va_gnt_o` are all zero.
- R2: A non-head request (valid=1, head=0) competes for the crossbar only when the credit flag of its held output VC (`ovc_credit_i` bit port*4+vc) is 1. With that flag 0 it receives no grant.
- R3: A head request to output port p is assigned the lowest-index output VC of p whose free flag (`ovc_free_i` bit p*4+vc) is 1. The assigned index appears on `va_ovc_o`. At most one head per output port is assigned per cycle, and none is assigned when p has no free VC.
- R4: A head request bids for the crossbar in the same cycle as its VC allocation. It moves (`sw_gnt_o`=1) in that cycle when it wins both the VC and the output and the assigned VC has credit.
- R5: Non-speculative requests win over speculative ones. This holds at each output, and at each input, where a port with any eligible non-head request forwards only a non-head request.
- R6: A speculative crossbar grant whose flit failed VC allocation in that cycle, or whose assigned VC has no credit, raises `sw_abort_o` for that input. In that case `sw_gnt_o` is 0 and the output's `out_vld_o` is 0.
- R7: Each output drives at most one input and each input moves at most one flit per cycle. The number of set `sw_gnt_o` bits equals the number of set `out_vld_o` bits, and `out_sel_o` gives the binary index of the granted input.
- R8: All arbitration is least-recently-served. After reset, lower indices win. A winner drops to lowest priority, so two persistent contenders alternate.
- R9: After an abort, the input's VC arbiter is left unchanged, so the same input VC is chosen again in the next cycle and can then move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_vld_i | input | 20 | Input VC holds a flit at its buffer front, index port*4+vc |
| req_head_i | input | 20 | Flit is a head still needing an output VC |
| req_port_i | input | 60 | Binary output port per input VC, 3 bits each; values 5..7 ignored |
| req_ovc_i | input | 40 | Held output VC per input VC, 2 bits each, used when head=0 |
| ovc_free_i | input | 20 | Output VC idle flag, index outport*4+vc |
| ovc_credit_i | input | 20 | Output VC credit counter non-zero, index outport*4+vc |
| va_gnt_o | output | 20 | Input VC is assigned an output VC this cycle |
| va_ovc_o | output | 40 | Assigned output VC index per input VC |
| sw_gnt_o | output | 5 | Input port moves a flit this cycle |
| sw_ivc_o | output | 10 | Binary input VC chosen per input port |
| sw_abort_o | output | 5 | Speculative grant of the input port was aborted |
| out_vld_o | output | 5 | Output port carries a flit this cycle |
| out_sel_o | output | 15 | Binary input index driving each output |

## Verification
Single isolated requests, one non-speculative and one speculative, establish the basic grant and VC-assignment paths. Masking a credit flag or every free flag then shows that each qualifier really gates its path. Mixed traffic is used next. A non-speculative and a speculative request aimed at one output separate the priority rule from plain index order. An input whose non-head request hides its own head, while a second input's head loses VC allocation, produces an abort that index order alone would not explain. The following cycle shows whether the same VC is retried. Persistent two-way contention at an output and within one input tells least-recently-served order apart from fixed priority. A five-way pile-up on one output confirms that exactly one flit moves.

// File: rtl/spec_alloc_pkg.sv
package spec_alloc_pkg;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned NUM_VCS   = 4;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/spec_lrs_arb.sv
module spec_lrs_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         upd_i,
  output logic [N-1:0] gnt_o
);
  // pri_q[a][b]: requester a beats requester b
  logic [N-1:0][N-1:0] pri_q;
  logic [N-1:0][N-1:0] beats_me;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) beats_me[i][j] = pri_q[j][i] && (j != i);
      gnt_o[i] = req_i[i] && ((req_i & beats_me[i]) == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++) pri_q[a][b] <= (a < b);
    end else if (upd_i) begin
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          if (gnt_o[a])      pri_q[a][b] <= 1'b0;
          else if (gnt_o[b]) pri_q[a][b] <= 1'b1;
    end
  end

  a_r7_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r7_gnt_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  a_r8_work_conserving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r8_winner_demoted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && gnt_o[k]) |=> ((pri_q[k] & ~(N'(1) << k)) == '0));
  end
endmodule

// File: rtl/spec_va_alloc.sv
module spec_va_alloc #(
  parameter int unsigned P  = 5,
  parameter int unsigned V  = 4,
  parameter int unsigned PW = 3,
  parameter int unsigned VW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [P*V-1:0]    head_req_i,
  input  logic [P*V*PW-1:0] req_port_i,
  input  logic [P*V-1:0]    ovc_free_i,
  output logic [P*V-1:0]    va_gnt_o,
  output logic [P*V*VW-1:0] va_ovc_o
);
  localparam int unsigned NI = P * V;

  logic [P-1:0][VW-1:0] first_free;
  logic [P-1:0]         any_free;
  logic [P-1:0][NI-1:0] port_req;
  logic [P-1:0][NI-1:0] port_gnt;

  always_comb begin
    for (int o = 0; o < P; o++) begin
      any_free[o]   = |ovc_free_i[o*V +: V];
      first_free[o] = '0;
      for (int v = int'(V) - 1; v >= 0; v--)
        if (ovc_free_i[o*V + v]) first_free[o] = VW'(v);
    end
  end

  always_comb begin
    port_req = '0;
    va_ovc_o = '0;
    for (int k = 0; k < NI; k++)
      for (int o = 0; o < P; o++)
        if (req_port_i[k*PW +: PW] == PW'(o)) begin
          port_req[o][k]         = head_req_i[k] && any_free[o];
          va_ovc_o[k*VW +: VW]   = first_free[o];
        end
  end

  for (genvar o = 0; o < P; o++) begin : g_port
    spec_lrs_arb #(.N(NI)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (port_req[o]),
      .upd_i  (|port_req[o]),
      .gnt_o  (port_gnt[o])
    );
  end

  always_comb begin
    va_gnt_o = '0;
    for (int o = 0; o < P; o++) va_gnt_o = va_gnt_o | port_gnt[o];
  end
endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
  parameter int unsigned P  = 5,
  parameter int unsigned V  = 4,
  parameter int unsigned PW = 3,
  parameter int unsigned VW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [P*V-1:0]    ns_req_i,
  input  logic [P*V-1:0]    sp_req_i,
  input  logic [P*V*PW-1:0] req_port_i,
  input  logic [P-1:0]      in_upd_i,
  output logic [P-1:0]      in_gnt_o,
  output logic [P*VW-1:0]   in_ivc_o,
  output logic [P-1:0]      in_spec_o,
  output logic [P-1:0]      out_vld_o,
  output logic [P*PW-1:0]   out_sel_o
);
  logic [P-1:0][V-1:0]  ns_gnt, sp_gnt, pick;
  logic [P-1:0]         in_vld, use_ns;
  logic [P-1:0][PW-1:0] in_port;
  logic [P-1:0][P-1:0]  o_ns_req, o_sp_req, o_ns_gnt, o_sp_gnt, o_gnt;

  // Input stage: one candidate VC per input, non-speculative first
  for (genvar i = 0; i < P; i++) begin : g_in
    spec_lrs_arb #(.N(V)) u_ns_arb (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .req_i (ns_req_i[i*V +: V]),
      .upd_i (in_upd_i[i] && use_ns[i]),
      .gnt_o (ns_gnt[i])
    );
    spec_lrs_arb #(.N(V)) u_sp_arb (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .req_i (sp_req_i[i*V +: V]),
      .upd_i (in_upd_i[i] && !use_ns[i]),
      .gnt_o (sp_gnt[i])
    );
  end

  always_comb begin
    in_ivc_o = '0;
    in_port  = '0;
    for (int i = 0; i < P; i++) begin
      use_ns[i]    = |ns_req_i[i*V +: V];
      pick[i]      = use_ns[i] ? ns_gnt[i] : sp_gnt[i];
      in_vld[i]    = |pick[i];
      in_spec_o[i] = !use_ns[i];
      for (int v = 0; v < V; v++)
        if (pick[i][v]) begin
          in_ivc_o[i*VW +: VW] = VW'(v);
          in_port[i]           = req_port_i[(i*V + v)*PW +: PW];
        end
    end
  end

  // Output stage: separate arbiters, non-speculative path always wins
  always_comb begin
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++) begin
        o_ns_req[o][i] = in_vld[i] &&  use_ns[i] && (in_port[i] == PW'(o));
        o_sp_req[o][i] = in_vld[i] && !use_ns[i] && (in_port[i] == PW'(o));
      end
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    spec_lrs_arb #(.N(P)) u_ns_arb (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .req_i (o_ns_req[o]),
      .upd_i (|o_ns_req[o]),
      .gnt_o (o_ns_gnt[o])
    );
    spec_lrs_arb #(.N(P)) u_sp_arb (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .req_i (o_sp_req[o]),
      .upd_i ((|o_sp_req[o]) && !(|o_ns_req[o])),
      .gnt_o (o_sp_gnt[o])
    );

    a_r5_out_ns_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|o_ns_req[o]) |-> ((o_gnt[o] & ~use_ns) == '0));
  end

  always_comb begin
    in_gnt_o  = '0;
    out_sel_o = '0;
    for (int o = 0; o < P; o++) begin
      o_gnt[o]     = (|o_ns_req[o]) ? o_ns_gnt[o] : o_sp_gnt[o];
      out_vld_o[o] = |o_gnt[o];
      in_gnt_o     = in_gnt_o | o_gnt[o];
      for (int i = 0; i < P; i++)
        if (o_gnt[o][i]) out_sel_o[o*PW +: PW] = PW'(i);
    end
  end
endmodule

// File: rtl/spec_vcsw_alloc.sv
module spec_vcsw_alloc #(
  parameter int unsigned NUM_PORTS = spec_alloc_pkg::NUM_PORTS,
  parameter int unsigned NUM_VCS   = spec_alloc_pkg::NUM_VCS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic [NUM_PORTS*NUM_VCS-1:0] req_vld_i,
  input  logic [NUM_PORTS*NUM_VCS-1:0] req_head_i,
  input  logic [NUM_PORTS*NUM_VCS*spec_alloc_pkg::idx_w(NUM_PORTS)-1:0] req_port_i,
  input  logic [NUM_PORTS*NUM_VCS*spec_alloc_pkg::idx_w(NUM_VCS)-1:0]   req_ovc_i,
  input  logic [NUM_PORTS*NUM_VCS-1:0] ovc_free_i,
  input  logic [NUM_PORTS*NUM_VCS-1:0] ovc_credit_i,
  output logic [NUM_PORTS*NUM_VCS-1:0] va_gnt_o,
  output logic [NUM_PORTS*NUM_VCS*spec_alloc_pkg::idx_w(NUM_VCS)-1:0] va_ovc_o,
  output logic [NUM_PORTS-1:0] sw_gnt_o,
  output logic [NUM_PORTS*spec_alloc_pkg::idx_w(NUM_VCS)-1:0] sw_ivc_o,
  output logic [NUM_PORTS-1:0] sw_abort_o,
  output logic [NUM_PORTS-1:0] out_vld_o,
  output logic [NUM_PORTS*spec_alloc_pkg::idx_w(NUM_PORTS)-1:0] out_sel_o
);
  localparam int unsigned P  = NUM_PORTS;
  localparam int unsigned V  = NUM_VCS;
  localparam int unsigned NI = P * V;
  localparam int unsigned PW = spec_alloc_pkg::idx_w(P);
  localparam int unsigned VW = spec_alloc_pkg::idx_w(V);

  logic [NI-1:0] head_req, ns_req, sp_req;
  logic [P-1:0]  port_free;
  logic [P-1:0]  in_gnt, in_spec, spec_ok, raw_out_vld;
  logic [P*PW-1:0] raw_out_sel;

  // Request qualification: credit for owners, any idle VC for heads
  always_comb begin
    for (int o = 0; o < P; o++) port_free[o] = |ovc_free_i[o*V +: V];
    for (int k = 0; k < NI; k++) begin
      head_req[k] = req_vld_i[k] && req_head_i[k];
      ns_req[k]   = 1'b0;
      sp_req[k]   = 1'b0;
      for (int o = 0; o < P; o++)
        if (req_port_i[k*PW +: PW] == PW'(o)) begin
          sp_req[k] = head_req[k] && port_free[o];
          for (int v = 0; v < V; v++)
            if (req_ovc_i[k*VW +: VW] == VW'(v))
              ns_req[k] = req_vld_i[k] && !req_head_i[k] && ovc_credit_i[o*V + v];
        end
    end
  end

  spec_va_alloc #(.P(P), .V(V), .PW(PW), .VW(VW)) u_va (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_req_i (head_req),
    .req_port_i (req_port_i),
    .ovc_free_i (ovc_free_i),
    .va_gnt_o   (va_gnt_o),
    .va_ovc_o   (va_ovc_o)
  );

  spec_sw_alloc #(.P(P), .V(V), .PW(PW), .VW(VW)) u_sw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ns_req_i   (ns_req),
    .sp_req_i   (sp_req),
    .req_port_i (req_port_i),
    .in_upd_i   (sw_gnt_o),
    .in_gnt_o   (in_gnt),
    .in_ivc_o   (sw_ivc_o),
    .in_spec_o  (in_spec),
    .out_vld_o  (raw_out_vld),
    .out_sel_o  (raw_out_sel)
  );

  // Abort detection: speculative winner must hold a fresh VC with credit
  always_comb begin
    for (int i = 0; i < P; i++) begin
      spec_ok[i] = 1'b0;
      for (int v = 0; v < V; v++)
        if (sw_ivc_o[i*VW +: VW] == VW'(v))
          for (int o = 0; o < P; o++)
            if (req_port_i[(i*V + v)*PW +: PW] == PW'(o))
              for (int w = 0; w < V; w++)
                if (va_ovc_o[(i*V + v)*VW +: VW] == VW'(w))
                  spec_ok[i] = va_gnt_o[i*V + v] && ovc_credit_i[o*V + w];
      sw_abort_o[i] = in_gnt[i] && in_spec[i] && !spec_ok[i];
      sw_gnt_o[i]   = in_gnt[i] && !sw_abort_o[i];
    end
  end

  always_comb begin
    out_sel_o = raw_out_sel;
    for (int o = 0; o < P; o++) begin
      out_vld_o[o] = 1'b0;
      for (int i = 0; i < P; i++)
        if (raw_out_sel[o*PW +: PW] == PW'(i))
          out_vld_o[o] = raw_out_vld[o] && !sw_abort_o[i];
    end
  end

  // Checker helpers
  logic [NI-1:0]        chk_free_ok;
  logic [P-1:0][NI-1:0] chk_va_to_port;
  logic [P-1:0]         chk_mv_head, chk_mv_credit, chk_has_ns;

  always_comb begin
    chk_va_to_port = '0;
    for (int k = 0; k < NI; k++) begin
      chk_free_ok[k] = 1'b0;
      for (int o = 0; o < P; o++)
        if (req_port_i[k*PW +: PW] == PW'(o)) begin
          chk_va_to_port[o][k] = va_gnt_o[k];
          for (int w = 0; w < V; w++)
            if (va_ovc_o[k*VW +: VW] == VW'(w)) chk_free_ok[k] = ovc_free_i[o*V + w];
        end
    end
    for (int i = 0; i < P; i++) begin
      chk_has_ns[i]    = |ns_req[i*V +: V];
      chk_mv_head[i]   = 1'b0;
      chk_mv_credit[i] = 1'b0;
      for (int v = 0; v < V; v++)
        if (sw_ivc_o[i*VW +: VW] == VW'(v)) begin
          chk_mv_head[i] = req_head_i[i*V + v];
          for (int o = 0; o < P; o++)
            if (req_port_i[(i*V + v)*PW +: PW] == PW'(o))
              for (int w = 0; w < V; w++)
                if (req_ovc_i[(i*V + v)*VW +: VW] == VW'(w))
                  chk_mv_credit[i] = ovc_credit_i[o*V + w];
        end
    end
  end

  a_r7_grant_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sw_gnt_o) == $countones(out_vld_o));

  for (genvar k = 0; k < NI; k++) begin : g_chk_vc
    a_r3_free_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      va_gnt_o[k] |-> (chk_free_ok[k] && req_vld_i[k] && req_head_i[k]));
  end

  for (genvar o = 0; o < P; o++) begin : g_chk_port
    a_r3_one_per_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(chk_va_to_port[o]) <= 1);
  end

  for (genvar i = 0; i < P; i++) begin : g_chk_in
    a_r2_credit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_gnt_o[i] && !chk_mv_head[i]) |-> chk_mv_credit[i]);
    a_r5_input_ns_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_gnt[i] && chk_has_ns[i]) |-> !chk_mv_head[i]);
    a_r6_abort_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_abort_o[i] |-> (!sw_gnt_o[i] && chk_mv_head[i]));
    a_r4_spec_has_vc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_gnt_o[i] && chk_mv_head[i]) |-> (|va_gnt_o[i*V +: V]));
  end
endmodule

// File: tb/spec_vcsw_alloc_bench.sv
module spec_vcsw_alloc_bench;
  localparam int P  = 5;
  localparam int V  = 4;
  localparam int PW = 3;
  localparam int VW = 2;
  localparam int NI = P * V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    req_vld, req_head, ovc_free, ovc_credit;
  logic [NI*PW-1:0] req_port;
  logic [NI*VW-1:0] req_ovc;
  logic [NI-1:0]    va_gnt;
  logic [NI*VW-1:0] va_ovc;
  logic [P-1:0]     sw_gnt, sw_abort, out_vld;
  logic [P*VW-1:0]  sw_ivc;
  logic [P*PW-1:0]  out_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spec_vcsw_alloc u_spec_vcsw_alloc (
    .clk_i (clk), .rst_ni (rst_n),
    .req_vld_i (req_vld), .req_head_i (req_head),
    .req_port_i (req_port), .req_ovc_i (req_ovc),
    .ovc_free_i (ovc_free), .ovc_credit_i (ovc_credit),
    .va_gnt_o (va_gnt), .va_ovc_o (va_ovc),
    .sw_gnt_o (sw_gnt), .sw_ivc_o (sw_ivc), .sw_abort_o (sw_abort),
    .out_vld_o (out_vld), .out_sel_o (out_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ivc_of(input int i);
    return int'(sw_ivc[i*VW +: VW]);
  endfunction
  function automatic int sel_of(input int o);
    return int'(out_sel[o*PW +: PW]);
  endfunction
  function automatic int vaovc_of(input int k);
    return int'(va_ovc[k*VW +: VW]);
  endfunction

  task automatic clear_all();
    req_vld = '0; req_head = '0; req_port = '0; req_ovc = '0;
    ovc_free = '0; ovc_credit = '1;
  endtask

  task automatic set_req(input int p, input int v, input bit head, input int port, input int ovc);
    req_vld[p*V + v]           = 1'b1;
    req_head[p*V + v]          = head;
    req_port[(p*V + v)*PW +: PW] = PW'(port);
    req_ovc[(p*V + v)*VW +: VW]  = VW'(ovc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_all();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic t_idle();
    do_reset();
    settle();
    chk("R1 sw_gnt idle", int'(sw_gnt), 0);
    chk("R1 out_vld idle", int'(out_vld), 0);
    chk("R1 va_gnt idle", int'(va_gnt), 0);
    chk("R1 abort idle", int'(sw_abort), 0);
  endtask

  task automatic t_nonspec_credit();
    do_reset();
    set_req(0, 2, 1'b0, 3, 1);
    settle();
    chk("R2 ns grant", int'(sw_gnt[0]), 1);
    chk("R2 ns ivc", ivc_of(0), 2);
    chk("R7 out3 vld", int'(out_vld[3]), 1);
    chk("R7 out3 sel", sel_of(3), 0);
    @(negedge clk);
    ovc_credit[3*V + 1] = 1'b0;
    settle();
    chk("R2 no credit no grant", int'(sw_gnt[0]), 0);
    chk("R2 no credit out", int'(out_vld), 0);
  endtask

  task automatic t_spec_success();
    do_reset();
    set_req(1, 0, 1'b1, 2, 0);
    ovc_free[2*V +: V] = 4'b1100;
    settle();
    chk("R3 va grant", int'(va_gnt[4]), 1);
    chk("R3 lowest free", vaovc_of(4), 2);
    chk("R4 spec moves", int'(sw_gnt[1]), 1);
    chk("R4 no abort", int'(sw_abort[1]), 0);
    chk("R4 out2 sel", sel_of(2), 1);
    @(negedge clk);
    ovc_free[2*V +: V] = 4'b1010;
    settle();
    chk("R3 lowest free 1010", vaovc_of(4), 1);
    @(negedge clk);
    ovc_free[2*V +: V] = 4'b0000;
    settle();
    chk("R3 none free no va", int'(va_gnt[4]), 0);
    chk("R3 none free no sw", int'(sw_gnt[1]), 0);
    chk("R3 none free no abort", int'(sw_abort[1]), 0);
  endtask

  task automatic t_priority();
    do_reset();
    set_req(1, 0, 1'b0, 4, 3);
    set_req(0, 0, 1'b1, 4, 0);
    ovc_free[4*V] = 1'b1;
    settle();
    chk("R5 ns wins out4", sel_of(4), 1);
    chk("R5 ns moves", int'(sw_gnt[1]), 1);
    chk("R5 spec loses", int'(sw_gnt[0]), 0);
    chk("R5 loser not abort", int'(sw_abort[0]), 0);
    chk("R3 va independent", int'(va_gnt[0]), 1);
  endtask

  task automatic t_abort_retry();
    do_reset();
    set_req(0, 0, 1'b1, 1, 0);
    set_req(0, 1, 1'b0, 3, 0);
    set_req(2, 0, 1'b1, 1, 0);
    set_req(2, 1, 1'b1, 1, 0);
    ovc_free[1*V +: V] = 4'b1000;
    settle();
    chk("R5 input ns first", int'(sw_gnt[0]), 1);
    chk("R5 input ns ivc", ivc_of(0), 1);
    chk("R3 va to idx0", int'(va_gnt[0]), 1);
    chk("R3 va ovc3", vaovc_of(0), 3);
    chk("R3 one per port", int'(va_gnt[8]) + int'(va_gnt[9]), 0);
    chk("R6 abort raised", int'(sw_abort[2]), 1);
    chk("R6 aborted no move", int'(sw_gnt[2]), 0);
    chk("R6 out1 idle", int'(out_vld[1]), 0);
    @(negedge clk);
    req_vld[0] = 1'b0; req_vld[1] = 1'b0;
    ovc_free[1*V +: V] = 4'b0100;
    settle();
    chk("R9 retry moves", int'(sw_gnt[2]), 1);
    chk("R9 retry same vc", ivc_of(2), 0);
    chk("R9 retry va", int'(va_gnt[8]), 1);
    chk("R9 retry no abort", int'(sw_abort[2]), 0);
    chk("R9 out1 sel", sel_of(1), 2);
  endtask

  task automatic t_spec_no_credit();
    do_reset();
    set_req(3, 1, 1'b1, 0, 0);
    ovc_free[0] = 1'b1;
    ovc_credit[0] = 1'b0;
    settle();
    chk("R6 va still granted", int'(va_gnt[13]), 1);
    chk("R6 no credit abort", int'(sw_abort[3]), 1);
    chk("R6 no credit no move", int'(sw_gnt[3]), 0);
    chk("R6 no credit out0", int'(out_vld[0]), 0);
  endtask

  task automatic t_output_lrs();
    do_reset();
    set_req(0, 0, 1'b0, 2, 0);
    set_req(3, 0, 1'b0, 2, 1);
    settle();
    chk("R8 reset order", sel_of(2), 0);
    @(negedge clk); settle();
    chk("R8 alternate", sel_of(2), 3);
    @(negedge clk); settle();
    chk("R8 alternate back", sel_of(2), 0);
  endtask

  task automatic t_input_lrs();
    do_reset();
    set_req(1, 0, 1'b0, 0, 0);
    set_req(1, 3, 1'b0, 4, 0);
    settle();
    chk("R8 in vc first", ivc_of(1), 0);
    @(negedge clk); settle();
    chk("R8 in vc second", ivc_of(1), 3);
    chk("R8 in vc out4", int'(out_vld[4]), 1);
    @(negedge clk); settle();
    chk("R8 in vc third", ivc_of(1), 0);
  endtask

  task automatic t_pileup();
    do_reset();
    for (int i = 0; i < P; i++) set_req(i, 0, 1'b0, 0, i % V);
    settle();
    chk("R7 one winner", $countones(sw_gnt), 1);
    chk("R7 one output", $countones(out_vld), 1);
    chk("R7 winner sel", sel_of(0), 0);
  endtask

  initial begin
    clear_all();
    t_idle();
    t_nonspec_credit();
    t_spec_success();
    t_priority();
    t_abort_retry();
    t_spec_no_credit();
    t_output_lrs();
    t_input_lrs();
    t_pileup();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule